// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is a serial peripheral interface master driven entirely through a small 32-bit register port. Software programs a configuration word that selects clock idle level, clock phase, bit order, word length (4 to 16 bits, or 32 bits), a clock prescaler and an internal loopback path. It then writes a word into the transmit location. The block shifts that word out on `mosi` while toggling `sck`, and samples `miso` on the opposite clock edge. When the word is complete it places the received bits, right-justified, in the receive location.

Two sticky event flags report progress. One says a received word is waiting. The other says the one-word transmit holding buffer has room. Each flag can be routed to the `irq` output through a mask. A second transmit write may be issued while a word is still shifting. It waits in the holding buffer and starts at the very next bit-clock slot, so the line carries no idle gap between the two words.

The register port has no back-pressure and no stream handshake. Every access completes in the cycle it is presented, and reads return combinationally from the addressed location. Software paces itself with the event flags.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the configuration register reads 0x2E7F0000. This means clock idles high, extra divide-by-16 on, most-significant-bit first, master on, enable off, length code 7 and prescale modulus 15. The event register reads 0x00000100, the mask reads 0, `irq` is low and `sck` is high.
- R2: Word offsets on `bus_addr` are 0 configuration, 1 events, 2 mask, 3 transmit (write), 4 receive (read). The configuration bits are:
  - bit 30: loopback
  - bit 29: clock idles high
  - bit 28: late phase
  - bit 27: extra divide-by-16
  - bit 26: MSB first
  - bit 25: master
  - bit 24: enable
  - bits 23:20: length code
  - bits 19:16: prescale modulus PM

  All other configuration bits read as 0.
- R3: While enable is set, a configuration write updates only the enable bit. Every other field keeps its value. While enable is clear, the whole configuration is written.
- R4: Length code c in 3..15 selects c+1 bits per word, and code 0 selects 32 bits. Transmit bits come from the low end of the written word. Received bits are right-justified with the upper bits zero.
- R5: With bit 26 set, words go out and come in most-significant bit first. With bit 26 clear, they go least-significant bit first.
- R6: `sck` rests at the bit 29 level and makes exactly two transitions per bit.
  - With bit 28 clear, `miso` is sampled on each leading transition and `mosi` changes on trailing ones.
  - With bit 28 set, `mosi` changes on leading transitions after the first, and `miso` is sampled on trailing ones.
- R7: Each `sck` half period lasts 2×(PM+1) clock cycles, or 32×(PM+1) clock cycles when bit 27 is set.
- R8: With loopback set, the receive path takes the block's own `mosi` stream and `miso` has no effect.
- R9: Event bit 9 (receive not empty) sets when a finished word lands in the receive register. Event bit 8 (transmit not full) sets when the shifter takes the held word. Writing 1 to an event bit clears it, and writing 0 leaves it. A setting condition wins over a clear in the same cycle.
- R10: A transmit write always goes through the one-word holding buffer and clears bit 8. Bit 8 stays clear until the shifter takes that word. A word held during a transfer starts right after the current word, with no idle half period between them.
- R11: `irq` is high exactly when some event bit is set whose mask bit (same position, 9 or 8) is set.
- R12: While enable or master is clear, the shifter is idle and `sck` rests at its idle level. A held word waits until the core is enabled again. Clearing enable in the middle of a word abandons it without posting a receive event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-rate source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when high together with `bus_sel` |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Masked event request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
On every cycle, the embedded properties check four things:
- the configuration fields stay frozen while enabled;
- a transmit write always leaves the holding buffer full with bit 8 clear;
- bit 9 only ever rises after a completed word;
- the shifter drops to idle, with `sck` at its rest level, one cycle after the core is disabled.

The bench's scenarios cover what a property cannot express over a whole word. A behavioural slave exchanges words with the block under random polarity, phase, bit order, length and prescale. The bench counts edges and half periods, runs back-to-back words with no gap, and shows that a word abandoned mid-transfer is never posted.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NBW    = $clog2(REG_W) + 1;

  localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVT  = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_TX   = 3'd3;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd4;

  localparam int unsigned B_NE     = 9;
  localparam int unsigned B_NF     = 8;
  localparam int unsigned B_EN     = 24;
  localparam int unsigned CFG_LO   = 16;
  localparam int unsigned CFG_HI   = 30;

  // Packed so that the field order lands on configuration bits 30..16.
  typedef struct packed {
    logic       loop;
    logic       cpol;
    logic       cpha;
    logic       div16;
    logic       msb;
    logic       master;
    logic       en;
    logic [3:0] len;
    logic [3:0] pm;
  } spim_cfg_t;

  localparam spim_cfg_t CFG_RESET = '{loop: 1'b0, cpol: 1'b1, cpha: 1'b0,
                                      div16: 1'b1, msb: 1'b1, master: 1'b1,
                                      en: 1'b0, len: 4'd7, pm: 4'hF};

  function automatic logic [NBW-1:0] word_bits(input logic [3:0] code);
    return (code == 4'd0) ? NBW'(REG_W) : NBW'(code) + 1'b1;
  endfunction
endpackage

// File: rtl/spim_baud.sv
module spim_baud
  import spim_pkg::*;
#(
  parameter int unsigned HALF_BASE = 2,
  parameter int unsigned SLOW_MUL  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       div16,
  input  logic [3:0] pm,
  output logic       tick
);
  localparam int unsigned CNT_W = $clog2(HALF_BASE * SLOW_MUL * 16) + 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] limit;

  always_comb begin
    span = CNT_W'(pm) + 1'b1;
    span = span * CNT_W'(HALF_BASE);
    if (div16) span = span * CNT_W'(SLOW_MUL);
    limit = span - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (cnt == limit) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == limit);
endmodule

// File: rtl/spim_shift.sv
module spim_shift
  import spim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             msb,
  input  logic             loop,
  input  logic [3:0]       len_code,
  input  logic             tick,
  input  logic             hold_full,
  input  logic [REG_W-1:0] hold_word,
  input  logic             miso,
  output logic             busy,
  output logic             take,
  output logic             done,
  output logic [REG_W-1:0] rx_word,
  output logic             sck,
  output logic             mosi
);
  localparam int unsigned ECW = $clog2(2 * REG_W);

  logic [NBW-1:0]   nbits;
  logic [NBW-1:0]   sh;
  logic [ECW-1:0]   edge_cnt;
  logic [ECW-1:0]   last_idx;
  logic             phase;
  logic             leading;
  logic             last;
  logic             sample;
  logic             advance;
  logic             in_bit;
  logic [REG_W-1:0] txsr;
  logic [REG_W-1:0] rxsr;
  logic [REG_W-1:0] rx_next;

  assign nbits    = word_bits(len_code);
  assign sh       = NBW'(REG_W) - nbits;
  assign last_idx = ECW'({nbits, 1'b0} - 1'b1);
  assign leading  = ~edge_cnt[0];
  assign last     = (edge_cnt == last_idx);
  assign sample   = tick && (cpha ? !leading : leading);
  assign advance  = tick && (cpha ? (leading && edge_cnt != '0) : (!leading && !last));
  assign mosi     = msb ? txsr[REG_W-1] : txsr[0];
  assign in_bit   = loop ? mosi : miso;
  assign sck      = cpol ^ phase;
  assign done     = tick && last;
  assign take     = run && hold_full && (!busy || done);

  always_comb begin
    rx_next = rxsr;
    if (sample) rx_next = msb ? {rxsr[REG_W-2:0], in_bit} : {in_bit, rxsr[REG_W-1:1]};
  end

  assign rx_word = msb ? rx_next : (rx_next >> sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; edge_cnt <= '0; phase <= 1'b0; txsr <= '0; rxsr <= '0;
    end else if (!run) begin
      busy <= 1'b0; edge_cnt <= '0; phase <= 1'b0;
    end else if (take) begin
      busy <= 1'b1; edge_cnt <= '0; phase <= 1'b0; rxsr <= '0;
      txsr <= msb ? (hold_word << sh) : hold_word;
    end else if (tick) begin
      phase <= ~phase;
      rxsr  <= rx_next;
      if (advance) txsr <= msb ? (txsr << 1) : (txsr >> 1);
      if (last) begin
        busy <= 1'b0; edge_cnt <= '0;
      end else begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end
  end

  // R12: one cycle after the core is switched off, nothing shifts and sck rests.
  p_off_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!busy && sck == cpol));

  // R6: a word never runs past two transitions per bit.
  p_edge_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (edge_cnt <= last_idx));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic              take,
  input  logic              done,
  input  logic [REG_W-1:0]  rx_word,
  output spim_cfg_t         cfg,
  output logic              hold_full,
  output logic [REG_W-1:0]  hold_word,
  output logic              irq
);
  logic             wr_cfg, wr_evt, wr_mask, wr_tx;
  logic             evt_ne, evt_nf;
  logic             msk_ne, msk_nf;
  logic [REG_W-1:0] rx_q;
  logic             unused_wdata;

  assign wr_cfg  = bus_sel && bus_wr && (bus_addr == A_CFG);
  assign wr_evt  = bus_sel && bus_wr && (bus_addr == A_EVT);
  assign wr_mask = bus_sel && bus_wr && (bus_addr == A_MASK);
  assign wr_tx   = bus_sel && bus_wr && (bus_addr == A_TX);
  assign unused_wdata = ^{bus_wdata[31], bus_wdata[15:10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= CFG_RESET;
      evt_ne    <= 1'b0;
      evt_nf    <= 1'b1;
      msk_ne    <= 1'b0;
      msk_nf    <= 1'b0;
      hold_full <= 1'b0;
      hold_word <= '0;
      rx_q      <= '0;
    end else begin
      if (wr_cfg) begin
        if (cfg.en) cfg.en <= bus_wdata[B_EN];
        else        cfg    <= bus_wdata[CFG_HI:CFG_LO];
      end
      if (wr_mask) begin
        msk_ne <= bus_wdata[B_NE];
        msk_nf <= bus_wdata[B_NF];
      end
      if (done)                         evt_ne <= 1'b1;
      else if (wr_evt && bus_wdata[B_NE]) evt_ne <= 1'b0;
      if (wr_tx)                        evt_nf <= 1'b0;
      else if (take)                    evt_nf <= 1'b1;
      else if (wr_evt && bus_wdata[B_NF]) evt_nf <= 1'b0;
      if (wr_tx) begin
        hold_full <= 1'b1;
        hold_word <= bus_wdata;
      end else if (take) begin
        hold_full <= 1'b0;
      end
      if (done) rx_q <= rx_word;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = {1'b0, cfg, 16'h0000};
      A_EVT:   bus_rdata = {22'h0, evt_ne, evt_nf, 8'h00};
      A_MASK:  bus_rdata = {22'h0, msk_ne, msk_nf, 8'h00};
      A_RX:    bus_rdata = rx_q;
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (evt_ne && msk_ne) || (evt_nf && msk_nf);

  // R3: configuration fields other than enable are frozen while enabled.
  p_cfg_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.en |=> $stable({cfg.loop, cfg.cpol, cfg.cpha, cfg.div16, cfg.msb,
                        cfg.master, cfg.len, cfg.pm}));

  // R10: a transmit write fills the holding buffer and drops not-full.
  p_nf_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> (hold_full && !evt_nf));

  // R9: receive-not-empty only rises after a finished word.
  p_ne_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_ne) |-> $past(done));
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int unsigned HALF_BASE = 2,
  parameter int unsigned SLOW_MUL  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        sck,
  output logic        mosi,
  input  logic        miso
);
  spim_cfg_t        cfg;
  logic             hold_full;
  logic [REG_W-1:0] hold_word;
  logic             take, done, busy, tick, run;
  logic [REG_W-1:0] rx_word;

  assign run = cfg.en && cfg.master;

  spim_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .take      (take),
    .done      (done),
    .rx_word   (rx_word),
    .cfg       (cfg),
    .hold_full (hold_full),
    .hold_word (hold_word),
    .irq       (irq)
  );

  spim_baud #(.HALF_BASE(HALF_BASE), .SLOW_MUL(SLOW_MUL)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy && run),
    .div16 (cfg.div16),
    .pm    (cfg.pm),
    .tick  (tick)
  );

  spim_shift u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .cpol      (cfg.cpol),
    .cpha      (cfg.cpha),
    .msb       (cfg.msb),
    .loop      (cfg.loop),
    .len_code  (cfg.len),
    .tick      (tick),
    .hold_full (hold_full),
    .hold_word (hold_word),
    .miso      (miso),
    .busy      (busy),
    .take      (take),
    .done      (done),
    .rx_word   (rx_word),
    .sck       (sck),
    .mosi      (mosi)
  );
endmodule

// File: tb/spim_ctrl_tb.sv
module spim_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq, sck, mosi, miso;

  always #2 clk = ~clk;

  spim_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  int checks = 0, fails = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // Behavioural slave
  logic cpol_m = 1'b1, cpha_m = 1'b0, msb_m = 1'b1;
  int n_m = 8;
  logic [31:0] slv_tx = 32'h0, slv_rx = 32'h0;
  int lead_cnt = 0, trail_cnt = 0, cap_cnt = 0, edges = 0;
  int unsigned last_c = 0, gap_min = 0, gap_max = 0;

  always @(posedge sck or negedge sck) begin
    int unsigned g;
    logic smp;
    smp = (sck != cpol_m) ? !cpha_m : cpha_m;
    if (smp) begin
      if (cap_cnt < n_m) begin
        if (msb_m) slv_rx[n_m-1-cap_cnt] = mosi;
        else       slv_rx[cap_cnt] = mosi;
      end
      cap_cnt++;
    end
    if (sck != cpol_m) lead_cnt++;
    else               trail_cnt++;
    if (edges > 0) begin
      g = cyc - last_c;
      if (edges == 1 || g < gap_min) gap_min = g;
      if (g > gap_max) gap_max = g;
    end
    last_c = cyc;
    edges++;
  end

  always_comb begin
    int idx;
    idx = cpha_m ? ((lead_cnt == 0) ? 0 : lead_cnt - 1) : trail_cnt;
    if (idx < n_m) miso = msb_m ? slv_tx[n_m-1-idx] : slv_tx[idx];
    else           miso = 1'b0;
  end

  task automatic clear_slave();
    lead_cnt = 0; trail_cnt = 0; cap_cnt = 0; edges = 0;
    gap_min = 0; gap_max = 0; slv_rx = 32'h0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic int bits_of(input int code);
    return (code == 0) ? 32 : code + 1;
  endfunction

  function automatic logic [31:0] lowmask(input int n);
    return (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  function automatic logic [31:0] cfg_word(input logic loop, cpol, cpha, div16, msb, en,
                                           input int code, input int pm);
    return {1'b0, loop, cpol, cpha, div16, msb, 1'b1, en, 4'(code), 4'(pm), 16'h0};
  endfunction

  function automatic int unsigned half_of(input logic div16, input int pm);
    return 2 * (pm + 1) * (div16 ? 16 : 1);
  endfunction

  task automatic setup(input logic loop, cpol, cpha, div16, msb, input int code, input int pm);
    wr(3'd0, cfg_word(loop, cpol, cpha, div16, msb, 1'b0, code, pm));
    wr(3'd0, cfg_word(loop, cpol, cpha, div16, msb, 1'b1, code, pm));
    cpol_m = cpol; cpha_m = cpha; msb_m = msb; n_m = bits_of(code);
  endtask

  task automatic xfer(input logic [31:0] tx, input logic [31:0] slv, output logic [31:0] rx);
    logic [31:0] ev;
    int tries;
    clear_slave();
    slv_tx = slv;
    wr(3'd3, tx);
    tries = 0;
    ev = 32'h0;
    while (ev[9] !== 1'b1 && tries < 40000) begin
      rd(3'd1, ev);
      tries++;
    end
    rd(3'd4, rx);
    wr(3'd1, 32'h200);
  endtask

  always @(posedge clk) begin
    if (cyc == 190000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, rx, ta, tb;
    int e_snap;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1", "cfg reset", v, 32'h2E7F0000);
    rd(3'd1, v); chk("R1", "event reset", v, 32'h00000100);
    rd(3'd2, v); chk("R1", "mask reset", v, 32'h0);
    chk("R1", "irq reset", {31'h0, irq}, 32'h0);
    chk("R1", "sck reset", {31'h0, sck}, 32'h1);

    // R2 field positions, R3 lock while enabled
    wr(3'd0, 32'hFEFF_FFFF); rd(3'd0, v); chk("R2", "cfg field mask", v, 32'h7EFF0000);
    wr(3'd0, 32'h0370_0000); rd(3'd0, v); chk("R3", "write while off", v, 32'h03700000);
    wr(3'd0, 32'h7DFF_0000); rd(3'd0, v); chk("R3", "fields frozen", v, 32'h03700000);
    wr(3'd0, 32'h7CFF_0000); rd(3'd0, v); chk("R3", "only enable clears", v, 32'h02700000);
    wr(3'd0, 32'h0000_0000); rd(3'd0, v); chk("R3", "full write once off", v, 32'h0);

    // R4 R5 R6 R7 R8 random transfers against the slave model
    for (int i = 0; i < 40; i++) begin
      int r, code, pm, n;
      logic loop, cpol, cpha, div16, msb;
      logic [31:0] tx, sv, erx;
      r = int'($urandom_range(0, 13));
      code = (r == 13) ? 0 : r + 3;
      div16 = ($urandom_range(0, 7) == 0);
      pm = div16 ? int'($urandom_range(0, 1)) : int'($urandom_range(0, 3));
      loop = $urandom_range(0, 3) == 0;
      cpol = 1'($urandom); cpha = 1'($urandom); msb = 1'($urandom);
      tx = $urandom; sv = $urandom;
      n = bits_of(code);
      setup(loop, cpol, cpha, div16, msb, code, pm);
      xfer(tx, sv, rx);
      erx = loop ? (tx & lowmask(n)) : (sv & lowmask(n));
      chk(loop ? "R8" : "R4", "received word", rx, erx);
      chk("R5", "slave captured", slv_rx & lowmask(n), tx & lowmask(n));
      chk("R6", "edge count", 32'(edges), 32'(2 * n));
      chk("R7", "half period min", gap_min, half_of(div16, pm));
      chk("R7", "half period max", gap_max, half_of(div16, pm));
    end

    // R4 directed 32-bit word, LSB first, late phase
    setup(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 0, 0);
    xfer(32'h8000_0001, 32'hC3A5_5A3C, rx);
    chk("R4", "32-bit receive", rx, 32'hC3A5_5A3C);
    chk("R5", "32-bit lsb-first send", slv_rx, 32'h8000_0001);

    // R7 slow divider
    setup(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 3, 2);
    xfer(32'hFFFF_FFF9, 32'h0, rx);
    chk("R8", "loopback ignores miso", rx, 32'h9);
    chk("R7", "div16 half period", gap_max, 32'd96);

    // R10 back-to-back words through the holding buffer
    setup(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 7, 0);
    wr(3'd1, 32'hFFFF_FFFF);
    clear_slave();
    ta = 32'h5C; tb = 32'hA3;
    wr(3'd3, ta);
    repeat (4) @(negedge clk);
    wr(3'd3, tb);
    rd(3'd1, v); chk("R10", "not-full drops", v & 32'h100, 32'h0);
    repeat (150) @(negedge clk);
    rd(3'd4, rx); chk("R10", "second word received", rx, tb);
    chk("R10", "no idle gap edges", 32'(edges), 32'd32);
    chk("R10", "no idle gap period", gap_max, 32'd2);
    rd(3'd1, v); chk("R9", "both events set", v, 32'h300);

    // R9 R11 events and interrupt
    wr(3'd2, 32'h0); chk("R11", "irq masked off", {31'h0, irq}, 32'h0);
    wr(3'd2, 32'h200); chk("R11", "irq on not-empty", {31'h0, irq}, 32'h1);
    wr(3'd1, 32'h100); rd(3'd1, v); chk("R9", "selective clear", v, 32'h200);
    wr(3'd1, 32'h200); rd(3'd1, v); chk("R9", "all clear", v, 32'h0);
    chk("R11", "irq after clear", {31'h0, irq}, 32'h0);
    wr(3'd2, 32'h100);
    wr(3'd3, 32'h11);
    repeat (100) @(negedge clk);
    chk("R11", "irq on not-full", {31'h0, irq}, 32'h1);
    wr(3'd2, 32'h0);
    wr(3'd1, 32'h300);

    // R12 disabled core holds a word until enabled
    setup(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 7, 0);
    wr(3'd1, 32'h300);
    wr(3'd0, cfg_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 7, 0));
    clear_slave();
    wr(3'd3, 32'hA5);
    repeat (200) @(negedge clk);
    chk("R12", "sck idle while off", {31'h0, sck}, 32'h1);
    chk("R12", "no edges while off", 32'(edges), 32'h0);
    rd(3'd1, v); chk("R12", "no receive while off", v & 32'h200, 32'h0);
    wr(3'd0, cfg_word(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 7, 0));
    repeat (100) @(negedge clk);
    rd(3'd4, rx); chk("R12", "held word sent", rx, 32'hA5);

    // R12 abandon mid-word
    setup(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 7, 15);
    wr(3'd1, 32'h300);
    clear_slave();
    wr(3'd3, 32'h3C);
    repeat (1500) @(negedge clk);
    wr(3'd0, cfg_word(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 7, 15));
    repeat (20) @(negedge clk);
    e_snap = edges;
    chk("R12", "sck rests after abort", {31'h0, sck}, 32'h0);
    wr(3'd0, cfg_word(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 7, 15));
    repeat (3000) @(negedge clk);
    chk("R12", "no restart after abort", 32'(edges), 32'(e_snap));
    rd(3'd1, v); chk("R12", "abandoned word not posted", v & 32'h200, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule